// File: doc/BRIEF.md
# Multidrop Serial Transmitter with Post-Frame Guard Time

This block serialises 8-bit characters onto a single idle-high line for a shared bus where several receivers listen. Every frame carries a ninth bit in the slot that normally holds parity. That bit tells receivers whether the character is an address (bit high) or data (bit low), so that a receiver can ignore traffic until it sees its own address.

Software writes characters into a one-entry holding register. A one-cycle command strobe marks the next accepted character as an address, and the mark is then used up. An 8-bit guard count adds that many idle-high bit periods after the stop bit(s) of each frame, which gives slow remote devices time to recover. Bit timing comes from an external baud tick, one tick per bit period. The ready flag shows that the holding register is free. The empty flag shows that nothing is held, nothing is being shifted and no guard time is running.

Top module: `mdrop_tx`

## Requirements
- R1: A frame is a low start bit, then the eight data bits least significant first, then the marker bit, then the stop bit(s), all high after the start bit except where data or the marker is low.
- R2: A character accepted without a pending address command is sent with the marker bit at 0.
- R3: A pulse on `addr_cmd` marks the next character accepted by `thr_wr` as an address, sent with the marker bit at 1. A pulse in the same cycle as the accepted write also applies to that write.
- R4: The address mark applies to one character only. The character accepted after it carries marker 0 unless a new command is given.
- R5: `two_stop` = 0 gives one stop bit and `two_stop` = 1 gives two. The value is sampled when a character moves into the shifter.
- R6: `guard_bits` = N adds N idle-high bit periods after the stop bit(s), and N = 0 adds none. The value is sampled when a character moves into the shifter.
- R7: `tx_empty` is high only when the holding register is free and no frame is active. It stays low through the guard period.
- R8: `tx_ready` is low while the holding register is full. When a character is waiting, it stays low through the stop and guard periods of the current frame and rises in the first cycle of the waiting character's start bit.
- R9: A `thr_wr` while `tx_ready` is low is ignored. The held character is sent unchanged and no extra frame follows.
- R10: After reset `txd`, `tx_ready` and `tx_empty` are all high, and `txd` stays high whenever no frame is active.
- R11: Each bit lasts exactly one baud tick period. A held character starts at the first tick on which the line is free, so back-to-back frames leave no gap beyond stop and guard bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_wr | input | 1 | Write strobe for the holding register |
| thr_data | input | 8 | Character to send |
| addr_cmd | input | 1 | One-cycle command: next accepted character is an address |
| guard_bits | input | 8 | Idle bit periods added after each frame |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial line, idle high |
| tx_ready | output | 1 | Holding register free |
| tx_empty | output | 1 | Nothing held, shifted or guarded |

## Verification
The bench sweeps guard counts 0 to 3, both stop settings and three ways of marking addresses: no mark, a strobe a cycle early, and a strobe in the same cycle as the write. It rebuilds every frame bit by bit from the line and checks its exact length. A design that leaked the address mark into the following character would show marker 1 on the second frame of the back-to-back runs. A design that raised ready or empty at the stop bit instead of after the guard would fail the flag checks taken one cycle before the next start bit. A write accepted while the register was full would appear as a corrupted second frame, or as a third frame on a line that must stay idle.

// File: rtl/mdrop_tx.sv
module mdrop_tx #(
  parameter int DW = 8,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_wr,
  input  logic [DW-1:0] thr_data,
  input  logic          addr_cmd,
  input  logic [GW-1:0] guard_bits,
  input  logic          two_stop,
  input  logic          baud_tick,
  output logic          txd,
  output logic          tx_ready,
  output logic          tx_empty
);
  localparam int CW = (GW > $clog2(DW)) ? GW : $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_MARK, S_STOP, S_GUARD} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [GW-1:0] greg;
  logic [DW-1:0] shreg, hold_data;
  logic          hold_valid, hold_addr, addr_pend, mark, stop2;
  logic          frame_done, load;

  assign frame_done = (state == S_STOP && cnt == '0 && greg == '0) ||
                      (state == S_GUARD && cnt == '0);
  assign load       = baud_tick && hold_valid && (state == S_IDLE || frame_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      greg       <= '0;
      shreg      <= '0;
      hold_data  <= '0;
      hold_valid <= 1'b0;
      hold_addr  <= 1'b0;
      addr_pend  <= 1'b0;
      mark       <= 1'b0;
      stop2      <= 1'b0;
    end else begin
      if (addr_cmd) addr_pend <= 1'b1;
      if (thr_wr && !hold_valid) begin
        hold_valid <= 1'b1;
        hold_data  <= thr_data;
        hold_addr  <= addr_pend | addr_cmd;
        addr_pend  <= 1'b0;
      end
      if (load) begin
        state      <= S_START;
        shreg      <= hold_data;
        mark       <= hold_addr;
        greg       <= guard_bits;
        stop2      <= two_stop;
        hold_valid <= 1'b0;
      end else if (baud_tick) begin
        case (state)
          S_START: begin
            state <= S_DATA;
            cnt   <= CW'(DW - 1);
          end
          S_DATA: begin
            shreg <= shreg >> 1;
            if (cnt == '0) state <= S_MARK;
            else           cnt   <= cnt - 1'b1;
          end
          S_MARK: begin
            state <= S_STOP;
            cnt   <= stop2 ? CW'(1) : '0;
          end
          S_STOP: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else if (greg != '0) begin
              state <= S_GUARD;
              cnt   <= CW'(greg - 1'b1);
            end else state <= S_IDLE;
          end
          S_GUARD: begin
            if (cnt != '0) cnt   <= cnt - 1'b1;
            else           state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      S_START: txd = 1'b0;
      S_DATA:  txd = shreg[0];
      S_MARK:  txd = mark;
      default: txd = 1'b1;
    endcase
  end

  assign tx_ready = !hold_valid;
  assign tx_empty = !hold_valid && state == S_IDLE;

  p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE || state == S_GUARD) |-> txd);

  p_empty_implies_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_ready);

  p_ready_rises_at_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> (state == S_START && !txd));

  p_full_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !tx_ready) |=> $stable(hold_data));

  p_bits_on_ticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(baud_tick) |-> $stable(txd));

  p_mark_consumed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && tx_ready && !addr_cmd) |=> !addr_pend);
endmodule

// File: tb/test_mdrop_tx.sv
module test_mdrop_tx;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       thr_wr = 1'b0;
  logic [7:0] thr_data = '0;
  logic       addr_cmd = 1'b0;
  logic [7:0] guard_bits = '0;
  logic       two_stop = 1'b0;
  logic       baud_tick = 1'b0;
  logic       txd, tx_ready, tx_empty;
  int         divcnt = 0;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    divcnt    <= (divcnt == DIV - 1) ? 0 : divcnt + 1;
    baud_tick <= (divcnt == DIV - 1);
  end

  mdrop_tx i_mdrop_tx (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_data(thr_data),
    .addr_cmd(addr_cmd), .guard_bits(guard_bits), .two_stop(two_stop),
    .baud_tick(baud_tick), .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_fall(input string req);
    bit seen = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!txd) begin seen = 1; break; end
    end
    chk(req, seen, 1);
  endtask

  // At the first sampled cycle of a start bit: walk the frame.
  task automatic frame(input logic [7:0] d, input bit mk, input int stops,
                       input int g, input bit queue, input logic [7:0] nxt,
                       input logic [7:0] junk);
    int n = 10 + stops + g;
    for (int c = 0; c <= n * DIV; c++) begin
      if (c > 0) @(negedge clk);
      if (c == 0 && queue) begin thr_wr = 1; thr_data = nxt; end
      if (c == 1) thr_wr = 0;
      if (c == 2 && queue) begin
        chk("R8 ready low while full", tx_ready, 0);
        thr_wr = 1; thr_data = junk;
      end
      if (c == 3) thr_wr = 0;
      if (c < n * DIV && c % DIV == 0) begin
        int b = c / DIV;
        if (b == 0) chk("R1 start bit", txd, 0);
        else if (b <= 8) chk("R1 data bit", txd, d[b-1]);
        else if (b == 9) chk(mk ? "R3 address marker" : "R2 data marker", txd, mk);
        else if (b < 10 + stops) chk("R5 stop bit", txd, 1);
        else chk("R6 guard idle", txd, 1);
        if (b >= 10 + stops) chk("R7 empty low in guard", tx_empty, 0);
      end
      if (c == n * DIV - 1) begin
        chk("R11 line high before boundary", txd, 1);
        chk("R8 ready before next start", tx_ready, queue ? 0 : 1);
      end
      if (c == n * DIV) begin
        if (queue) begin
          chk("R11 next start on time", txd, 0);
          chk("R8 ready rises at start", tx_ready, 1);
          chk("R7 empty low with next frame", tx_empty, 0);
        end else begin
          chk("R7 empty after guard", tx_empty, 1);
          chk("R10 idle high", txd, 1);
        end
      end
    end
  endtask

  task automatic write_char(input logic [7:0] d, input int mode);
    if (mode == 1) begin
      addr_cmd = 1;
      @(negedge clk);
      addr_cmd = 0;
    end
    thr_wr = 1; thr_data = d; addr_cmd = (mode == 2);
    @(negedge clk);
    thr_wr = 0; addr_cmd = 0;
    chk("R8 ready drops after write", tx_ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset txd", txd, 1);
    chk("R10 reset ready", tx_ready, 1);
    chk("R10 reset empty", tx_empty, 1);
    rst_n = 1;
    @(negedge clk);

    for (int g = 0; g < 4; g++)
      for (int s = 1; s <= 2; s++)
        for (int m = 0; m < 3; m++) begin
          logic [7:0] d = 8'hA5 ^ 8'(g * 37 + s * 11 + m * 73);
          guard_bits = 8'(g);
          two_stop   = (s == 2);
          write_char(d, m);
          wait_fall("R11 start after write");
          frame(d, m != 0, s, g, 0, 8'h00, 8'h00);
        end

    for (int g = 0; g < 3; g += 2)
      for (int s = 1; s <= 2; s++) begin
        logic [7:0] a = 8'h3C + 8'(g * 5 + s);
        logic [7:0] b = 8'hC3 ^ 8'(g + s * 17);
        bit quiet = 1;
        guard_bits = 8'(g);
        two_stop   = (s == 2);
        write_char(a, 1);
        wait_fall("R11 start after write");
        frame(a, 1, s, g, 1, b, 8'hFF);
        frame(b, 0, s, g, 0, 8'h00, 8'h00);   // R4 one-shot, R9 junk dropped
        for (int k = 0; k < 30 * DIV; k++) begin
          @(negedge clk);
          if (!txd) quiet = 0;
        end
        chk("R9 no extra frame after ignored write", quiet, 1);
      end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule